// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a regular tick for an operating-system scheduler. The system clock goes through a fixed divide-by-16 prescaler. Each prescaled tick advances a 20-bit interval counter. When that counter hits the programmed period it returns to zero, and the event is recorded. A 12-bit tally keeps count of the periods that have completed since software last acknowledged.

Software reaches the block through a small word-addressed register bus with four addresses: control, status, an acknowledging count read, and a side-effect-free count read. A level interrupt output follows the tick flag, gated by an interrupt-enable bit. Software stops the timer by clearing the enable bit. The current period still runs to completion and the counter then parks at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads zero: control, status, and both count reads. `irq` is low.
- R2: While the timer is counting, the interval counter advances by one every 16 clock cycles. The first advance comes on the 16th edge after the enable bit is written.
- R3: On a prescaled tick that finds the interval counter equal to the period field P, the counter returns to 0 instead of advancing. A period therefore lasts 16*(P+1) clocks.
- R4: The tally goes up by one on each completed period. It saturates at 4095 and never wraps.
- R5: The tick flag (status bit 0) sets on each completed period. `irq` equals the flag AND the interrupt-enable bit.
- R6: A read of address 2 returns the counts as they were before the read: interval counter in bits [19:0], tally in bits [31:20]. The same read clears the flag and the tally. If a period completes in that same cycle, the completion wins, leaving the flag set and the tally at 1.
- R7: A read of address 3 returns the same word as address 2 and changes no state.
- R8: Counting runs while control bit 24 (enable) is 1. When the bit is cleared, counting continues until the current period completes, then the interval counter and prescaler stay at 0.
- R9: Address 0 is the control register: bits [19:0] hold the period, bit 24 is enable and bit 25 is interrupt enable. Reads return only those bits; all other bits read 0.
- R10: `reg_rdata` is registered. It takes the read result on the clock edge that samples `reg_rd` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 acknowledging count, 3 count image |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Tick interrupt, level |

## Verification
Take E as the edge that loads the enable bit. The prescaler first moves on edge E+1. The interval counter first moves on edge E+16, and a period completes on edge E+16*(P+1). A read issued on edge E+k returns the state left by edge E+k-1. `irq` sampled after edge E+k already reflects that edge. The bench counts edges from the enabling write and schedules each read so that its edge lands on a chosen k. Its expected values use the k-1 rule for read data and the k rule for `irq`. The directed cases place reads exactly on the last edge before a tick and on a completion edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_VALUE = 2'd2,
    ADDR_PEEK  = 2'd3
  } pit_addr_e;

  localparam int EN_POS  = 24;
  localparam int IEN_POS = 25;

  // saturating increment on a generic 32-bit carrier
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // end of period: counter has reached (or passed) the programmed limit
  function automatic logic period_done(input logic [31:0] cnt, input logic [31:0] limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                active,
  output logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0] pre_q,
  output logic                                tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  assign tick = active && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (active) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter import pit_pkg::*; #(
  parameter int CNT_W   = 20,
  parameter int TALLY_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [CNT_W-1:0]   period,
  input  logic               ack,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [TALLY_W-1:0] tally_q,
  output logic               flag_q,
  output logic               wrap
);
  localparam logic [31:0] TALLY_MAX = 32'((64'd1 << TALLY_W) - 64'd1);

  logic [TALLY_W-1:0] tally_inc;

  assign wrap      = tick && period_done(32'(cnt_q), 32'(period));
  assign tally_inc = TALLY_W'(sat_inc(32'(tally_q), TALLY_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // completion dominates an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
      flag_q  <= 1'b0;
    end else if (wrap) begin
      tally_q <= ack ? TALLY_W'(1) : tally_inc;
      flag_q  <= 1'b1;
    end else if (ack) begin
      tally_q <= '0;
      flag_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs import pit_pkg::*; #(
  parameter int CNT_W   = 20,
  parameter int TALLY_W = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               rd,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [TALLY_W-1:0] tally,
  input  logic               flag,
  output logic [CNT_W-1:0]   period,
  output logic               en,
  output logic               ien,
  output logic               ack,
  output logic               peek,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] ctrl_word, stat_word, count_word, rd_word;
  logic unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:IEN_POS+1], wdata[EN_POS-1:CNT_W]};

  assign ack  = rd && (addr == ADDR_VALUE);
  assign peek = rd && (addr == ADDR_PEEK);

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      en     <= 1'b0;
      ien    <= 1'b0;
    end else if (wr && (addr == ADDR_CTRL)) begin
      period <= wdata[CNT_W-1:0];
      en     <= wdata[EN_POS];
      ien    <= wdata[IEN_POS];
    end
  end

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[CNT_W-1:0]    = period;
    ctrl_word[EN_POS]       = en;
    ctrl_word[IEN_POS]      = ien;
    stat_word               = '0;
    stat_word[0]            = flag;
    count_word              = '0;
    count_word[CNT_W-1:0]   = cnt;
    count_word[CNT_W +: TALLY_W] = tally;
    unique case (addr)
      ADDR_CTRL: rd_word = ctrl_word;
      ADDR_STAT: rd_word = stat_word;
      default:   rd_word = count_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer import pit_pkg::*; #(
  parameter int PRE_DIV = 16,
  parameter int CNT_W   = 20,
  parameter int TALLY_W = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  // named internal events, observed by the bound checker
  logic               tick_w, wrap_w, ack_w, peek_w, en_w, ien_w, flag_w, active_w;
  logic [PRE_W-1:0]   pre_w;
  logic [CNT_W-1:0]   cnt_w, period_w;
  logic [TALLY_W-1:0] tally_w;

  // keep running after enable drops until the period closes at zero
  assign active_w = en_w || (cnt_w != '0) || (pre_w != '0);
  assign irq      = flag_w && ien_w;

  pit_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .active(active_w), .pre_q(pre_w), .tick(tick_w)
  );

  pit_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .period(period_w), .ack(ack_w),
    .cnt_q(cnt_w), .tally_q(tally_w), .flag_q(flag_w), .wrap(wrap_w)
  );

  pit_regs #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(cnt_w), .tally(tally_w), .flag(flag_w),
    .period(period_w), .en(en_w), .ien(ien_w), .ack(ack_w), .peek(peek_w),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int PRE_W   = 4,
  parameter int CNT_W   = 20,
  parameter int TALLY_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_w,
  input logic               wrap_w,
  input logic               ack_w,
  input logic               peek_w,
  input logic               en_w,
  input logic [PRE_W-1:0]   pre_w,
  input logic [CNT_W-1:0]   cnt_w,
  input logic [TALLY_W-1:0] tally_w,
  input logic               flag_w
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_w |=> $stable(cnt_w));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> (cnt_w == '0));

  // R4
  tally_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&tally_w) && !ack_w |=> (&tally_w));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> flag_w);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack_w && !wrap_w |=> !flag_w && (tally_w == '0));

  // R7
  peek_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    peek_w && !wrap_w |=> $stable(tally_w) && $stable(flag_w));

  // R8
  parked_chk: assert property (@(posedge clk) disable iff (rst)
    !en_w && (cnt_w == '0) && (pre_w == '0) |=> (cnt_w == '0) && (pre_w == '0));
endmodule

bind pit_timer pit_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_chk (
  .clk(clk), .rst(rst), .tick_w(tick_w), .wrap_w(wrap_w), .ack_w(ack_w),
  .peek_w(peek_w), .en_w(en_w), .pre_w(pre_w), .cnt_w(cnt_w),
  .tally_w(tally_w), .flag_w(flag_w)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_err = 0, cyc = 0, ena_cyc = 0;
  bit done = 1'b0;
  logic [31:0] d;

  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] IEN = 32'h0200_0000;

  // vector table: period, irq enable, read edge k, expected counter, tally, irq
  localparam int NV = 5;
  localparam int V_P  [NV] = '{0, 2, 5, 1, 7};
  localparam int V_IE [NV] = '{1, 0, 1, 1, 1};
  localparam int V_K  [NV] = '{40, 100, 250, 20, 128};
  localparam int V_CNT[NV] = '{0, 0, 3, 1, 7};
  localparam int V_TAL[NV] = '{2, 2, 2, 0, 0};
  localparam int V_IRQ[NV] = '{1, 0, 1, 0, 1};

  pit_timer dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; v = reg_rdata;
  endtask

  // wait so the next access lands on edge ena_cyc + k
  task automatic wait_k(input int k);
    while ((cyc - ena_cyc) < k - 1) @(negedge clk);
  endtask

  task automatic rd_at(input int k, input logic [1:0] a, output logic [31:0] v);
    wait_k(k);
    rd_now(a, v);
  endtask

  function automatic logic [31:0] cw(input int c, input int t);
    return {t[11:0], c[19:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    rd_now(2'd0, d); check("R1 ctrl", d, 32'd0);
    rd_now(2'd1, d); check("R1 stat", d, 32'd0);
    rd_now(2'd3, d); check("R1 image", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // table of vectors (R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr_ctrl(EN | (V_IE[i] != 0 ? IEN : 32'd0) | 32'(V_P[i]));
      ena_cyc = cyc;
      rd_at(V_K[i], 2'd3, d);
      check("R3 R4 vector count", d, cw(V_CNT[i], V_TAL[i]));
      check("R5 vector irq", {31'd0, irq}, 32'(V_IRQ[i]));
    end

    // R6 R7 acknowledge and image, period 0
    do_reset();
    wr_ctrl(EN | IEN);
    ena_cyc = cyc;
    rd_at(35, 2'd3, d); check("R7 image first", d, cw(0, 2));
    rd_at(36, 2'd3, d); check("R7 image repeat", d, cw(0, 2));
    check("R7 irq kept", {31'd0, irq}, 32'd1);
    rd_at(40, 2'd2, d); check("R6 ack returns", d, cw(0, 2));
    check("R6 irq cleared", {31'd0, irq}, 32'd0);
    rd_at(41, 2'd3, d); check("R6 tally cleared", d, cw(0, 0));
    rd_at(42, 2'd1, d); check("R6 flag cleared", d, 32'd0);
    // R6 ack on a completion edge: completion wins
    rd_at(48, 2'd2, d); check("R6 collide return", d, cw(0, 0));
    rd_at(49, 2'd3, d); check("R6 collide tally", d, cw(0, 1));
    check("R6 collide irq", {31'd0, irq}, 32'd1);

    // R2 prescale and R8 disable mid period, period 3 (64 clocks)
    do_reset();
    wr_ctrl(EN | 32'd3);
    ena_cyc = cyc;
    rd_at(16, 2'd3, d); check("R2 before tick", d, cw(0, 0));
    rd_at(17, 2'd3, d); check("R2 after tick", d, cw(1, 0));
    wait_k(20); wr_ctrl(32'd3);
    rd_at(50, 2'd3, d); check("R8 still counting", d, cw(3, 0));
    rd_at(100, 2'd3, d); check("R8 finished period", d, cw(0, 1));
    rd_at(140, 2'd3, d); check("R8 parked", d, cw(0, 1));
    repeat (5) @(negedge clk);
    check("R10 rdata held", reg_rdata, cw(0, 1));

    // R9 control readback and R4 saturation
    do_reset();
    wr_ctrl(32'hFF00_0000);
    ena_cyc = cyc;
    rd_now(2'd0, d); check("R9 ctrl readback", d, 32'h0300_0000);
    rd_at(70000, 2'd3, d); check("R4 saturated", d, cw(0, 4095));
    check("R5 irq saturated run", {31'd0, irq}, 32'd1);
    wr_ctrl(32'h0100_0007);
    rd_now(2'd0, d); check("R9 ctrl fields", d, 32'h0100_0007);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule